// File: doc/BRIEF.md
# Serial Port FIFO Controller

This block sits between a host register interface and a byte-level asynchronous serial link. It keeps a 16-byte transmit queue and a 16-byte receive queue. It paces both queues from a frame tick that the baud timer supplies, which arrives once per character time. The block raises one-cycle pulses that set the transmit-empty, transmit-end, receive-full, data-ready, overrun and break-received flags, which live in a status register outside it. Bit shifting and parity belong to the link side and are not part of this block.

The host writes bytes into the transmit queue and pops bytes from the receive queue. It also writes a FIFO control register, which holds two queue flushes and two 2-bit threshold codes, and a port register, which drives the break pin. The block shows the fill level of both queues in a single count word. On each frame tick it sends at most one byte and accepts at most one byte. When the line is idle, it moves the first written byte straight to the link without queuing it. A break is sent one frame after the transmitter is disabled with the break pin driven low.

Top module: `sfifo_serial_ctrl`

## Requirements
- R1: After reset the count word is 0, the control register reads 0, no byte is sent, and every flag pulse is low.
- R2: If the transmitter is enabled, idle and its queue is empty, a written byte appears on `link_tx_byte` with `link_tx_valid` one cycle later. `set_tdfe` pulses in the same cycle and the transmit count stays 0.
- R3: While transmission is active, each frame tick sends the oldest queued byte. `set_tdfe` pulses when the count after that removal is at most the level picked by control bits 5:4 (code 0: 8, code 1: 4, code 2: 2, code 3: 1).
- R4: A frame tick that finds transmission active with an empty queue pulses `set_tend` and `set_tdfe` and ends transmission. The next write is then sent directly again.
- R5: Control bit 1 (transmit flush) clears the transmit queue and stops transmission, and transmit writes are ignored while it is set. When it goes from 1 to 0, `set_tend` and `set_tdfe` pulse.
- R6: When `seven_bit` is high, bit 7 of a written byte is cleared before the byte is sent or queued.
- R7: On a frame tick with `link_rx_valid` high, the byte is queued. `set_rdf` pulses when the count after the push reaches the level picked by control bits 7:6 (code 0: 1, code 1: 4, code 2: 8, code 3: 14).
- R8: A byte that arrives while the receive queue holds 16 bytes is dropped and `set_orer` pulses. The queue contents stay unchanged.
- R9: An incoming byte is discarded while `rx_enable` is low or control bit 0 (receive flush) is set. Receive flush also empties the receive queue.
- R10: A frame tick with no incoming byte while the receive queue is not empty pulses `set_dr`.
- R11: A receive read returns the oldest byte on `rxd_rdata` one cycle later and removes it. A read from an empty queue returns 0x00 and leaves the count at 0.
- R12: `fifo_count` carries the receive count in bits 4:0 and the transmit count in bits 12:8, and all other bits are 0.
- R13: Clearing `tx_enable` pulses `set_tend`. With the transmitter disabled, port bit 1 = 1 and port bit 0 = 0, one `link_brk_out` pulse follows the first frame tick after the condition arises. Removing the condition before that tick cancels the break.
- R14: A port write keeps the bits under mask 0xF3, and a port read always returns bit 4 as 0. A `link_brk_in` pulse is followed one cycle later by a `set_brk` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One pulse per character time from the baud timer |
| tx_enable | input | 1 | Transmitter enable |
| rx_enable | input | 1 | Receiver enable |
| seven_bit | input | 1 | 7-bit character mode |
| ctl_wr | input | 1 | FIFO control register write strobe |
| ctl_wdata | input | 8 | FIFO control write data |
| ctl_rdata | output | 8 | FIFO control readback |
| port_wr | input | 1 | Port register write strobe |
| port_wdata | input | 8 | Port register write data |
| port_rdata | output | 8 | Port register readback, bit 4 always 0 |
| txd_wr | input | 1 | Transmit data write strobe |
| txd_wdata | input | 8 | Transmit data byte |
| rxd_rd | input | 1 | Receive data read strobe |
| rxd_rdata | output | 8 | Receive data byte, registered |
| fifo_count | output | 16 | Receive and transmit fill levels |
| link_tx_byte | output | 8 | Byte handed to the shifter |
| link_tx_valid | output | 1 | Qualifies link_tx_byte for one cycle |
| link_rx_byte | input | 8 | Incoming byte from the link |
| link_rx_valid | input | 1 | Incoming byte present, sampled on frame_tick |
| link_brk_in | input | 1 | Break detected on the line |
| link_brk_out | output | 1 | Request to send a break |
| set_tdfe | output | 1 | Set pulse, transmit queue at or below threshold |
| set_tend | output | 1 | Set pulse, transmission ended |
| set_rdf | output | 1 | Set pulse, receive queue reached threshold |
| set_dr | output | 1 | Set pulse, data ready after a quiet frame |
| set_orer | output | 1 | Set pulse, receive overrun |
| set_brk | output | 1 | Set pulse, break received |

## Verification
The hardest situation to reach is a frame tick while transmission is active and the queue is at exactly one of the four threshold levels. This needs one byte already in the shifter, a precise number of queued bytes, and the right 2-bit code in the control register, all at once. The stimulus table reaches it for each code. It flushes the queue, writes one extra byte that goes straight to the shifter, then queues two more bytes than the threshold and steps two ticks. The first tick must leave the flag low and the second must raise it.

A second hard case is receive overrun, which needs sixteen accepted ticks in a row. After it, the bench drains the whole queue to show that the dropped byte never entered it.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // FIFO control register; bit positions are decoded by software
  typedef struct packed {
    logic [1:0] rx_code;   // 7:6 receive threshold code
    logic [1:0] tx_code;   // 5:4 transmit threshold code
    logic       spare;     // 3
    logic       modem;     // 2 modem control enable (held only)
    logic       tx_flush;  // 1
    logic       rx_flush;  // 0
  } fifo_ctl_t;

  function automatic int rx_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int tx_level(input logic [1:0] code);
    return 1 << (3 - int'(code));
  endfunction

endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full && !flush) |=> full); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> empty); // R11

endmodule

// File: rtl/sfc_tx.sv
module sfc_tx
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          seven_bit,
  input  logic          tx_flush,
  input  logic [1:0]    tx_code,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  output logic          set_tdfe,
  output logic          set_tend,
  output logic [CW-1:0] count
);

  logic       busy, flush_q, te_q;
  logic       wr_ok, direct, push, adv, adv_pop, adv_end, full, empty;
  logic [7:0] wbyte, head;

  assign wr_ok   = wr && !tx_flush;
  assign wbyte   = seven_bit ? {1'b0, wdata[6:0]} : wdata;
  assign adv     = tick && !tx_flush && (busy || tx_en);
  assign adv_pop = adv && !empty;
  assign adv_end = adv && empty && busy;
  assign direct  = wr_ok && tx_en && empty && (!busy || adv_end);
  assign push    = wr_ok && !direct;

  sfc_fifo #(.DEPTH(DEPTH), .W(8)) u_q (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(push), .pop(adv_pop),
    .wdata(wbyte), .head(head), .count(count), .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      flush_q  <= 1'b0;
      te_q     <= 1'b0;
      tx_byte  <= '0;
      tx_valid <= 1'b0;
      set_tdfe <= 1'b0;
      set_tend <= 1'b0;
    end else begin
      flush_q  <= tx_flush;
      te_q     <= tx_en;
      tx_valid <= 1'b0;
      set_tdfe <= 1'b0;
      set_tend <= 1'b0;
      if (tx_flush) begin
        busy <= 1'b0;
      end else if (direct) begin
        busy     <= 1'b1;
        tx_valid <= 1'b1;
        tx_byte  <= wbyte;
        set_tdfe <= 1'b1;
        if (adv_end) set_tend <= 1'b1;
      end else if (adv_pop) begin
        busy     <= 1'b1;
        tx_valid <= 1'b1;
        tx_byte  <= head;
        if (int'(count) - 1 <= tx_level(tx_code)) set_tdfe <= 1'b1;
      end else if (adv_end) begin
        busy     <= 1'b0;
        set_tend <= 1'b1;
        set_tdfe <= 1'b1;
      end
      if (flush_q && !tx_flush) begin
        set_tend <= 1'b1;
        set_tdfe <= 1'b1;
      end
      if (te_q && !tx_en) set_tend <= 1'b1;
    end
  end

  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> !tx_valid); // R5
  AST_SEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(wr || tick)); // R3

endmodule

// File: rtl/sfc_rx.sv
module sfc_rx
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          rx_flush,
  input  logic [1:0]    rx_code,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          rd,
  output logic [7:0]    rd_data,
  output logic          set_rdf,
  output logic          set_dr,
  output logic          set_orer,
  output logic [CW-1:0] count
);

  logic       take, push, full, empty;
  logic [7:0] head;

  assign take = tick && in_valid && rx_en && !rx_flush;
  assign push = take && !full;

  sfc_fifo #(.DEPTH(DEPTH), .W(8)) u_q (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(push), .pop(rd),
    .wdata(in_byte), .head(head), .count(count), .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      set_rdf  <= 1'b0;
      set_dr   <= 1'b0;
      set_orer <= 1'b0;
    end else begin
      if (rd) rd_data <= (empty || rx_flush) ? 8'h00 : head;
      set_rdf  <= push && (int'(count) + 1 >= rx_level(rx_code));
      set_dr   <= tick && !in_valid && !empty && !rx_flush;
      set_orer <= take && full;
    end
  end

  AST_DR_ON_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !in_valid && !empty && !rx_flush) |=> set_dr); // R10
  AST_ORER_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    set_orer |-> $past(full)); // R8

endmodule

// File: rtl/sfc_brk.sv
module sfc_brk (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_en,
  input  logic pin_oe,
  input  logic pin_lvl,
  input  logic brk_in,
  output logic brk_out,
  output logic set_brk
);

  logic cond, cond_q, armed;

  assign cond = !tx_en && pin_oe && !pin_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q  <= 1'b0;
      armed   <= 1'b0;
      brk_out <= 1'b0;
      set_brk <= 1'b0;
    end else begin
      cond_q  <= cond;
      armed   <= cond && (armed ? !tick : !cond_q);
      brk_out <= cond && armed && tick;
      set_brk <= brk_in;
    end
  end

  AST_BRK_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
    brk_out |-> ($past(cond) && $past(tick))); // R13

endmodule

// File: rtl/sfifo_serial_ctrl.sv
module sfifo_serial_ctrl
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_tick,
  input  logic        tx_enable,
  input  logic        rx_enable,
  input  logic        seven_bit,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  input  logic        port_wr,
  input  logic [7:0]  port_wdata,
  output logic [7:0]  port_rdata,
  input  logic        txd_wr,
  input  logic [7:0]  txd_wdata,
  input  logic        rxd_rd,
  output logic [7:0]  rxd_rdata,
  output logic [15:0] fifo_count,
  output logic [7:0]  link_tx_byte,
  output logic        link_tx_valid,
  input  logic [7:0]  link_rx_byte,
  input  logic        link_rx_valid,
  input  logic        link_brk_in,
  output logic        link_brk_out,
  output logic        set_tdfe,
  output logic        set_tend,
  output logic        set_rdf,
  output logic        set_dr,
  output logic        set_orer,
  output logic        set_brk
);

  localparam logic [7:0] PORT_KEEP = 8'hF3;
  localparam logic [7:0] CTS_CLEAR = 8'hEF;

  fifo_ctl_t     ctl_q;
  logic [7:0]    port_q;
  logic [CW-1:0] tx_cnt, rx_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      port_q <= '0;
    end else begin
      if (ctl_wr)  ctl_q  <= fifo_ctl_t'(ctl_wdata);
      if (port_wr) port_q <= port_wdata & PORT_KEEP;
    end
  end

  assign ctl_rdata  = ctl_q;
  assign port_rdata = port_q & CTS_CLEAR;

  always_comb begin
    fifo_count = '0;
    fifo_count[CW-1:0] = rx_cnt;
    fifo_count[8 +: CW] = tx_cnt;
  end

  sfc_tx #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .tick(frame_tick), .tx_en(tx_enable),
    .seven_bit(seven_bit), .tx_flush(ctl_q.tx_flush), .tx_code(ctl_q.tx_code),
    .wr(txd_wr), .wdata(txd_wdata), .tx_byte(link_tx_byte),
    .tx_valid(link_tx_valid), .set_tdfe(set_tdfe), .set_tend(set_tend),
    .count(tx_cnt)
  );

  sfc_rx #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .tick(frame_tick), .rx_en(rx_enable),
    .rx_flush(ctl_q.rx_flush), .rx_code(ctl_q.rx_code),
    .in_valid(link_rx_valid), .in_byte(link_rx_byte), .rd(rxd_rd),
    .rd_data(rxd_rdata), .set_rdf(set_rdf), .set_dr(set_dr),
    .set_orer(set_orer), .count(rx_cnt)
  );

  sfc_brk u_brk (
    .clk(clk), .rst(rst), .tick(frame_tick), .tx_en(tx_enable),
    .pin_oe(port_q[1]), .pin_lvl(port_q[0]), .brk_in(link_brk_in),
    .brk_out(link_brk_out), .set_brk(set_brk)
  );

  AST_COUNT_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (fifo_count[15:13] == 3'b0) && (fifo_count[7:5] == 3'b0)); // R12

endmodule

// File: tb/sim_sfifo_serial_ctrl.sv
module sim_sfifo_serial_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 0, tx_enable = 0, rx_enable = 0, seven_bit = 0;
  logic ctl_wr = 0, port_wr = 0, txd_wr = 0, rxd_rd = 0;
  logic [7:0] ctl_wdata = 0, port_wdata = 0, txd_wdata = 0, link_rx_byte = 0;
  logic link_rx_valid = 0, link_brk_in = 0;
  logic [7:0] ctl_rdata, port_rdata, rxd_rdata, link_tx_byte;
  logic [15:0] fifo_count;
  logic link_tx_valid, link_brk_out;
  logic set_tdfe, set_tend, set_rdf, set_dr, set_orer, set_brk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sfifo_serial_ctrl u0 (.*);

  // kind bit 15 (1 = transmit), code 13:12, expected level 7:0
  localparam logic [15:0] VEC [8] = '{
    16'h0001, 16'h1004, 16'h2008, 16'h300E,
    16'h8008, 16'h9004, 16'hA002, 16'hB001
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; step(); ctl_wr = 0;
  endtask

  task automatic wr_port(input logic [7:0] v);
    port_wr = 1; port_wdata = v; step(); port_wr = 0;
  endtask

  task automatic wr_tx(input logic [7:0] v);
    txd_wr = 1; txd_wdata = v; step(); txd_wr = 0;
  endtask

  task automatic tick(input logic vld, input logic [7:0] b);
    frame_tick = 1; link_rx_valid = vld; link_rx_byte = b;
    step();
    frame_tick = 0; link_rx_valid = 0;
  endtask

  task automatic rd_rx();
    rxd_rd = 1; step(); rxd_rd = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 count", fifo_count, 0);
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 txv", link_tx_valid, 0);
    chk("R1 pulses", {set_tdfe, set_tend, set_rdf, set_dr, set_orer, set_brk, link_brk_out}, 0);

    tx_enable = 1;
    rx_enable = 1;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] code;
      int lvl;
      code = VEC[i][13:12];
      lvl  = int'(VEC[i][7:0]);
      if (!VEC[i][15]) begin
        int first;
        first = 0;
        wr_ctl({code, 6'b000011});
        wr_ctl({code, 6'b000000});
        for (int k = 1; k <= 16; k++) begin
          tick(1, 8'(k));
          if (set_rdf && first == 0) first = k;
        end
        chk("R7 rx threshold", first, lvl);
      end else begin
        wr_ctl({2'b00, code, 4'b0011});
        wr_ctl({2'b00, code, 4'b0000});
        wr_tx(8'hF0);
        for (int k = 0; k < lvl + 2; k++) wr_tx(8'(k));
        tick(0, 0);
        chk("R3 tdfe above level", set_tdfe, 0);
        tick(0, 0);
        chk("R3 tdfe at level", set_tdfe, 1);
      end
    end
    wr_ctl(8'h03);
    wr_ctl(8'h00);
    step();

    // R2 direct send
    wr_tx(8'hA5);
    chk("R2 valid", link_tx_valid, 1);
    chk("R2 byte", link_tx_byte, 8'hA5);
    chk("R2 tdfe", set_tdfe, 1);
    chk("R2 count", fifo_count[12:8], 0);
    // R3 ordering
    wr_tx(8'h11);
    wr_tx(8'h22);
    chk("R3 queued", fifo_count, 16'h0200);
    tick(0, 0);
    chk("R3 first", {link_tx_valid, link_tx_byte}, 9'h111);
    tick(0, 0);
    chk("R3 second", {link_tx_valid, link_tx_byte}, 9'h122);
    tick(0, 0);
    chk("R4 end", {link_tx_valid, set_tend, set_tdfe}, 3'b011);
    wr_tx(8'h33);
    chk("R4 direct again", {link_tx_valid, link_tx_byte}, 9'h133);
    tick(0, 0);
    // R6 seven bit
    seven_bit = 1;
    wr_tx(8'hC3);
    chk("R6 masked", {link_tx_valid, link_tx_byte}, 9'h143);
    seven_bit = 0;
    tick(0, 0);

    // R5 transmit flush
    wr_tx(8'h01);
    wr_tx(8'h02);
    wr_ctl(8'h02);
    wr_tx(8'h77);
    chk("R5 cleared", fifo_count[12:8], 0);
    chk("R5 no send", link_tx_valid, 0);
    tick(0, 0);
    chk("R5 stopped", link_tx_valid, 0);
    wr_ctl(8'h00);
    step();
    chk("R5 release", {set_tend, set_tdfe}, 2'b11);
    wr_tx(8'h5A);
    chk("R5 idle after", {link_tx_valid, link_tx_byte}, 9'h15A);
    tick(0, 0);
    tick(0, 0);

    // R9 receive discard
    rx_enable = 0;
    tick(1, 8'h55);
    chk("R9 disabled", fifo_count[4:0], 0);
    rx_enable = 1;
    wr_ctl(8'h01);
    tick(1, 8'h66);
    chk("R9 flushing", fifo_count[4:0], 0);
    wr_ctl(8'h00);

    // R7 / R12
    tick(1, 8'h10);
    chk("R7 rdf level1", set_rdf, 1);
    tick(1, 8'h20);
    chk("R12 rx only", fifo_count, 16'h0002);
    wr_tx(8'h90);
    wr_tx(8'h91);
    wr_tx(8'h92);
    wr_tx(8'h93);
    chk("R12 both", fifo_count, 16'h0302);
    wr_ctl(8'h02);
    wr_ctl(8'h00);
    step();
    // R10 data ready
    tick(0, 0);
    chk("R10 dr", set_dr, 1);
    // R11 reads
    rxd_rd = 1;
    step();
    chk("R11 first", rxd_rdata, 8'h10);
    step();
    chk("R11 second", rxd_rdata, 8'h20);
    step();
    rxd_rd = 0;
    chk("R11 empty read", rxd_rdata, 8'h00);
    chk("R11 empty count", fifo_count[4:0], 0);
    tick(0, 0);
    chk("R10 no dr when empty", set_dr, 0);

    // R8 overrun
    for (int k = 0; k < 16; k++) tick(1, 8'(k));
    tick(1, 8'hEE);
    chk("R8 orer", set_orer, 1);
    chk("R8 count", fifo_count[4:0], 16);
    begin
      logic [7:0] last;
      last = 0;
      for (int k = 0; k < 16; k++) begin
        rd_rx();
        if (k == 0) chk("R8 head", rxd_rdata, 8'h00);
        last = rxd_rdata;
      end
      chk("R8 dropped", last, 8'h0F);
    end

    // R13 break
    wr_port(8'h02);
    tx_enable = 0;
    step();
    chk("R13 tend on disable", set_tend, 1);
    chk("R13 no early break", link_brk_out, 0);
    tick(0, 0);
    chk("R13 break", link_brk_out, 1);
    tick(0, 0);
    chk("R13 single break", link_brk_out, 0);
    wr_port(8'h00);
    wr_port(8'h02);
    wr_port(8'h03);
    tick(0, 0);
    chk("R13 cancelled", link_brk_out, 0);

    // R14 port readback, break in, control readback
    wr_port(8'hFF);
    chk("R14 port", port_rdata, 8'hE3);
    link_brk_in = 1;
    step();
    link_brk_in = 0;
    chk("R14 brk in", set_brk, 1);
    step();
    chk("R14 brk one", set_brk, 0);
    wr_ctl(8'hB4);
    chk("R14 ctl readback", ctl_rdata, 8'hB4);

    done = 1;
    summary();
    $finish;
  end

endmodule